// File: doc/BRIEF.md
# Dual-Bank Interrupt Router with Fast/Normal Outputs

This block gathers forty level-sensitive interrupt lines into two 32-bit banks. Lines 0 to 31 fill bank 0. Lines 32 to 39 fill bits 7:0 of bank 1. Each line has an enable bit and a steering bit. The steering bit sends the line either to the fast-interrupt output (`fiqOut`) or to the normal-interrupt output (`irqOut`). Each line first passes through a two-flop synchroniser. The second flop of that synchroniser is the pending bit, so a pending bit always follows its live input. Software never clears it.

A simple 32-bit register port gives software access to the enable and steering masks, the idle control and forty priority words. It can also read the raw pending bits and the two qualified pending views. While the core reports that it is halted, the block can raise a wake request. The wake request considers every pending line that is either enabled or allowed by a global idle mask. The highest-priority lookup is done by a neighbouring resolver. At that offset this block returns zero.

Top module: `irq_route_ctrl`

## Requirements
- R1: After a synchronous reset, the pending, enable and steering bits are zero and `irqOut`, `fiqOut` and `wakeOut` are low. The idle-control read at 0x14 returns 1.
- R2: Raw pending reads return the level that was on each source input two clocks earlier. The offsets are 0x10 for bank 0 (sources 31:0) and 0xAC for bank 1 (sources 39:32 in bits 7:0, upper bits zero).
- R3: One clock after any line is pending, enabled and steered (steering bit 1), `fiqOut` is high. Otherwise it is low. Both banks count.
- R4: One clock after any line is pending, enabled and not steered (steering bit 0), `irqOut` is high. Otherwise it is low. Both banks count.
- R5: Qualified reads return the normal view as pending AND enable AND NOT steering, at 0x00 and 0x9C. They return the fast view as pending AND enable AND steering, at 0x0C and 0xA8.
- R6: Enable masks are written and read at 0x04 and 0xA0. Steering masks are written and read at 0x08 and 0xA4. Bank 1 keeps only data bits 7:0 and reads bits 31:8 as zero.
- R7: A write to 0x14 with bit 0 = 1 empties the idle mask. A write with bit 0 = 0 fills it. The read at 0x14 returns 1 when the mask is empty and 0 otherwise.
- R8: One clock after `halted` is high and some pending line is enabled or allowed by the idle mask, `wakeOut` is high. Otherwise it is low.
- R9: Priority word k is at 0x1C+4k for k<32 and at 0xB0+4(k-32) for k≥32. A write stores data AND 0x8000003F, and a read returns the stored value.
- R10: Writes to the read-only offsets (0x00, 0x0C, 0x10, 0x9C, 0xA8, 0xAC) and to undefined or misaligned offsets change nothing. Reads of 0x18 and of every undefined offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srcIn | input | NUM_SRC | Asynchronous interrupt source levels |
| halted | input | 1 | Core is halted; enables wake evaluation |
| busAddr | input | ADDR_W | Register byte address, used for reads and writes |
| busWrEn | input | 1 | Write strobe for the current address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the current address, combinational |
| irqOut | output | 1 | Registered normal-interrupt request |
| fiqOut | output | 1 | Registered fast-interrupt request |
| wakeOut | output | 1 | Registered wake request while halted |

## Verification
The bench builds the block with its defaults: forty sources and an 8-bit address. With these values bank 1 is only partly filled, so the upper bits that must read zero and the ignored upper write data can be reached. They also put the last priority word at 0xCC, with undefined space directly above it. The bench sweeps all 256 byte addresses, including the misaligned ones. It also toggles source levels while steering and enables are mixed across both banks, so each output is seen rising and falling from either bank.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BANK_W     = 32;
  localparam int MAX_BANKS  = 2;
  localparam int PRIO_IDX_W = 6;
  localparam int PAD_W      = MAX_BANKS * BANK_W;

  typedef enum logic [2:0] {
    RD_NONE, RD_IRQP, RD_MASK, RD_ROUTE, RD_FIQP, RD_RAW, RD_CTRL, RD_PRIO
  } rdSel_e;

  typedef struct packed {
    logic [MAX_BANKS-1:0]  wrMask;
    logic [MAX_BANKS-1:0]  wrRoute;
    logic                  wrCtrl;
    logic                  wrPrio;
    rdSel_e                rdSel;
    logic                  rdBank;
    logic [PRIO_IDX_W-1:0] prioIdx;
  } regStrobe_t;
endpackage

// File: rtl/irqc_regctl.sv
module irqc_regctl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] OFF_B0_IRQP  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_B0_MASK  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_B0_ROUTE = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_B0_FIQP  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_B0_RAW   = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_CTRL     = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFF_B1_IRQP  = ADDR_W'(8'h9C);
  localparam logic [ADDR_W-1:0] OFF_B1_MASK  = ADDR_W'(8'hA0);
  localparam logic [ADDR_W-1:0] OFF_B1_ROUTE = ADDR_W'(8'hA4);
  localparam logic [ADDR_W-1:0] OFF_B1_FIQP  = ADDR_W'(8'hA8);
  localparam logic [ADDR_W-1:0] OFF_B1_RAW   = ADDR_W'(8'hAC);
  localparam logic [ADDR_W-1:0] PRIO0_BASE   = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] PRIO0_LAST   = PRIO0_BASE + ADDR_W'(4 * (BANK_W - 1));
  localparam logic [ADDR_W-1:0] PRIO1_BASE   = ADDR_W'(8'hB0);
  localparam logic [ADDR_W-1:0] PRIO1_LAST   = PRIO1_BASE + ADDR_W'(4 * (NUM_SRC - BANK_W - 1));

  logic              aligned;
  logic [ADDR_W-1:0] prioOff0;
  logic [ADDR_W-1:0] prioOff1;

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign prioOff0 = busAddr - PRIO0_BASE;
  assign prioOff1 = busAddr - PRIO1_BASE;

  always_comb begin
    strobe.wrMask  = '0;
    strobe.wrRoute = '0;
    strobe.wrCtrl  = 1'b0;
    strobe.wrPrio  = 1'b0;
    strobe.rdSel   = RD_NONE;
    strobe.rdBank  = 1'b0;
    strobe.prioIdx = '0;
    case (busAddr)
      OFF_B0_IRQP:  strobe.rdSel = RD_IRQP;
      OFF_B0_FIQP:  strobe.rdSel = RD_FIQP;
      OFF_B0_RAW:   strobe.rdSel = RD_RAW;
      OFF_B0_MASK: begin
        strobe.rdSel     = RD_MASK;
        strobe.wrMask[0] = busWrEn;
      end
      OFF_B0_ROUTE: begin
        strobe.rdSel      = RD_ROUTE;
        strobe.wrRoute[0] = busWrEn;
      end
      OFF_CTRL: begin
        strobe.rdSel  = RD_CTRL;
        strobe.wrCtrl = busWrEn;
      end
      OFF_B1_IRQP: begin
        strobe.rdSel  = RD_IRQP;
        strobe.rdBank = 1'b1;
      end
      OFF_B1_FIQP: begin
        strobe.rdSel  = RD_FIQP;
        strobe.rdBank = 1'b1;
      end
      OFF_B1_RAW: begin
        strobe.rdSel  = RD_RAW;
        strobe.rdBank = 1'b1;
      end
      OFF_B1_MASK: begin
        strobe.rdSel     = RD_MASK;
        strobe.rdBank    = 1'b1;
        strobe.wrMask[1] = busWrEn;
      end
      OFF_B1_ROUTE: begin
        strobe.rdSel      = RD_ROUTE;
        strobe.rdBank     = 1'b1;
        strobe.wrRoute[1] = busWrEn;
      end
      default: begin
        if (aligned && busAddr >= PRIO0_BASE && busAddr <= PRIO0_LAST) begin
          strobe.rdSel   = RD_PRIO;
          strobe.wrPrio  = busWrEn;
          strobe.prioIdx = prioOff0[PRIO_IDX_W+1:2];
        end else if (aligned && busAddr >= PRIO1_BASE && busAddr <= PRIO1_LAST) begin
          strobe.rdSel   = RD_PRIO;
          strobe.wrPrio  = busWrEn;
          strobe.prioIdx = PRIO_IDX_W'(BANK_W) + prioOff1[PRIO_IDX_W+1:2];
        end
      end
    endcase
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               halted,
  input  logic [BANK_W-1:0]  busWrData,
  input  regStrobe_t         strobe,
  output logic [BANK_W-1:0]  rdData,
  output logic               irqOut,
  output logic               fiqOut,
  output logic               wakeOut,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [NUM_SRC-1:0] maskVec,
  output logic [NUM_SRC-1:0] routeVec,
  output logic               idleAll
);
  localparam int PAD_FILL = PAD_W - NUM_SRC;

  logic [NUM_SRC-1:0] syncStage [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) syncStage[s] <= '0;
        else if (s == 0) syncStage[s] <= srcIn;
        else syncStage[s] <= syncStage[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign pendVec = syncStage[SYNC_STAGES-1];

  logic [PAD_W-1:0] pendPad, maskPad, routePad, maskNext, routeNext;
  assign pendPad  = {{PAD_FILL{1'b0}}, pendVec};
  assign maskPad  = {{PAD_FILL{1'b0}}, maskVec};
  assign routePad = {{PAD_FILL{1'b0}}, routeVec};

  always_comb begin
    maskNext  = maskPad;
    routeNext = routePad;
    for (int b = 0; b < MAX_BANKS; b++) begin
      if (strobe.wrMask[b])  maskNext[b*BANK_W +: BANK_W]  = busWrData;
      if (strobe.wrRoute[b]) routeNext[b*BANK_W +: BANK_W] = busWrData;
    end
  end

  logic                  prioValid [NUM_SRC];
  logic [PRIO_IDX_W-1:0] prioId    [NUM_SRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      maskVec  <= '0;
      routeVec <= '0;
      idleAll  <= 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
        prioValid[i] <= 1'b0;
        prioId[i]    <= '0;
      end
    end else begin
      maskVec  <= maskNext[NUM_SRC-1:0];
      routeVec <= routeNext[NUM_SRC-1:0];
      if (strobe.wrCtrl) idleAll <= ~busWrData[0];
      if (strobe.wrPrio && int'(strobe.prioIdx) < NUM_SRC) begin
        prioValid[strobe.prioIdx] <= busWrData[BANK_W-1];
        prioId[strobe.prioIdx]    <= busWrData[PRIO_IDX_W-1:0];
      end
    end
  end

  logic [NUM_SRC-1:0] liveVec, irqVec, fiqVec, wakeVec;
  assign liveVec = pendVec & maskVec;
  assign irqVec  = liveVec & ~routeVec;
  assign fiqVec  = liveVec & routeVec;
  assign wakeVec = pendVec & (maskVec | {NUM_SRC{idleAll}});

  always_ff @(posedge clk) begin
    if (rst) begin
      irqOut  <= 1'b0;
      fiqOut  <= 1'b0;
      wakeOut <= 1'b0;
    end else begin
      irqOut  <= |irqVec;
      fiqOut  <= |fiqVec;
      wakeOut <= halted && (|wakeVec);
    end
  end

  function automatic logic [BANK_W-1:0] pickBank(input logic [PAD_W-1:0] v, input logic hi);
    return hi ? v[PAD_W-1 -: BANK_W] : v[BANK_W-1:0];
  endfunction

  logic [PAD_W-1:0] irqPad, fiqPad;
  assign irqPad = pendPad & maskPad & ~routePad;
  assign fiqPad = pendPad & maskPad & routePad;

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      RD_IRQP:  rdData = pickBank(irqPad, strobe.rdBank);
      RD_FIQP:  rdData = pickBank(fiqPad, strobe.rdBank);
      RD_RAW:   rdData = pickBank(pendPad, strobe.rdBank);
      RD_MASK:  rdData = pickBank(maskPad, strobe.rdBank);
      RD_ROUTE: rdData = pickBank(routePad, strobe.rdBank);
      RD_CTRL:  rdData = {{(BANK_W-1){1'b0}}, ~idleAll};
      RD_PRIO: begin
        if (int'(strobe.prioIdx) < NUM_SRC)
          rdData = {prioValid[strobe.prioIdx], {(BANK_W-1-PRIO_IDX_W){1'b0}},
                    prioId[strobe.prioIdx]};
      end
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               halted,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [BANK_W-1:0]  busWrData,
  output logic [BANK_W-1:0]  busRdData,
  output logic               irqOut,
  output logic               fiqOut,
  output logic               wakeOut
);
  regStrobe_t         strobe;
  logic [NUM_SRC-1:0] pendVec, maskVec, routeVec;
  logic               idleAll;

  irqc_regctl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(2)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .srcIn     (srcIn),
    .halted    (halted),
    .busWrData (busWrData),
    .strobe    (strobe),
    .rdData    (busRdData),
    .irqOut    (irqOut),
    .fiqOut    (fiqOut),
    .wakeOut   (wakeOut),
    .pendVec   (pendVec),
    .maskVec   (maskVec),
    .routeVec  (routeVec),
    .idleAll   (idleAll)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               halted,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic [31:0]        busRdData,
  input logic               irqOut,
  input logic               fiqOut,
  input logic               wakeOut,
  input logic [NUM_SRC-1:0] pendVec,
  input logic [NUM_SRC-1:0] maskVec,
  input logic [NUM_SRC-1:0] routeVec,
  input logic               idleAll
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk)
    (armed === 1'b1) && $past(rst) |-> (!irqOut && !fiqOut && !wakeOut));

  p_fiq_has_source_r3: assert property (@(posedge clk) disable iff (rst)
    fiqOut |-> $past(|(pendVec & maskVec & routeVec)));

  p_irq_has_source_r4: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> $past(|(pendVec & maskVec & ~routeVec)));

  p_mask_holds_r6: assert property (@(posedge clk) disable iff (rst)
    !busWrEn |=> $stable(maskVec) && $stable(routeVec));

  p_ctrl_read_r7: assert property (@(posedge clk) disable iff (rst)
    (busAddr == ADDR_W'(8'h14)) |-> (busRdData == {31'b0, !idleAll}));

  p_wake_needs_halt_r8: assert property (@(posedge clk) disable iff (rst)
    wakeOut |-> $past(halted));

  p_undef_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (busAddr == ADDR_W'(8'h18) || busAddr > ADDR_W'(8'hCC)) |-> (busRdData == 32'b0));
endmodule

bind irq_route_ctrl irqc_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .halted    (halted),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdData (busRdData),
  .irqOut    (irqOut),
  .fiqOut    (fiqOut),
  .wakeOut   (wakeOut),
  .pendVec   (pendVec),
  .maskVec   (maskVec),
  .routeVec  (routeVec),
  .idleAll   (idleAll)
);

// File: tb/tb_irq_route_ctrl.sv
module tb_irq_route_ctrl;
  localparam int NSRC = 40;

  logic            clk = 1'b0;
  logic            rst;
  logic [NSRC-1:0] srcIn;
  logic            halted;
  logic [7:0]      busAddr;
  logic            busWrEn;
  logic [31:0]     busWrData;
  logic [31:0]     busRdData;
  logic            irqOut, fiqOut, wakeOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  irq_route_ctrl dut (
    .clk(clk), .rst(rst), .srcIn(srcIn), .halted(halted),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut), .fiqOut(fiqOut), .wakeOut(wakeOut)
  );

  always #2ns clk = ~clk;

  // Behavioural reference model
  logic [63:0] mSeen, mPend, mMask, mRoute;
  logic        mIdleEmpty;
  logic [31:0] mPrio [NSRC];
  logic        mIrq, mFiq, mWake;

  always @(posedge clk) begin
    if (rst) begin
      mSeen <= 0; mPend <= 0; mMask <= 0; mRoute <= 0;
      mIdleEmpty <= 1'b1;
      mIrq <= 0; mFiq <= 0; mWake <= 0;
      for (int i = 0; i < NSRC; i++) mPrio[i] <= 0;
    end else begin
      mSeen <= 64'(srcIn);
      mPend <= mSeen;
      mIrq  <= (mPend & mMask & ~mRoute) != 0;
      mFiq  <= (mPend & mMask & mRoute) != 0;
      mWake <= halted && ((mPend & (mIdleEmpty ? mMask : 64'hFFFF_FFFF_FFFF_FFFF)) != 0);
      if (busWrEn) begin
        case (busAddr)
          8'h04: mMask[31:0]   <= busWrData;
          8'hA0: mMask[39:32]  <= busWrData[7:0];
          8'h08: mRoute[31:0]  <= busWrData;
          8'hA4: mRoute[39:32] <= busWrData[7:0];
          8'h14: mIdleEmpty    <= busWrData[0];
          default: begin
            if (busAddr[1:0] == 0 && busAddr >= 8'h1C && busAddr <= 8'h98)
              mPrio[(int'(busAddr) - 28) / 4] <= busWrData & 32'h8000003F;
            else if (busAddr[1:0] == 0 && busAddr >= 8'hB0 && busAddr <= 8'hCC)
              mPrio[32 + (int'(busAddr) - 176) / 4] <= busWrData & 32'h8000003F;
          end
        endcase
      end
    end
  end

  function automatic logic [31:0] expRead(input logic [7:0] a);
    logic [63:0] q, f;
    q = mPend & mMask & ~mRoute;
    f = mPend & mMask & mRoute;
    case (a)
      8'h00: return q[31:0];
      8'h9C: return q[63:32];
      8'h0C: return f[31:0];
      8'hA8: return f[63:32];
      8'h10: return mPend[31:0];
      8'hAC: return mPend[63:32];
      8'h04: return mMask[31:0];
      8'hA0: return mMask[63:32];
      8'h08: return mRoute[31:0];
      8'hA4: return mRoute[63:32];
      8'h14: return {31'b0, mIdleEmpty};
      default: begin
        if (a[1:0] == 0 && a >= 8'h1C && a <= 8'h98) return mPrio[(int'(a) - 28) / 4];
        if (a[1:0] == 0 && a >= 8'hB0 && a <= 8'hCC) return mPrio[32 + (int'(a) - 176) / 4];
        return 32'b0;
      end
    endcase
  endfunction

  function automatic string readTag(input logic [7:0] a);
    case (a)
      8'h00, 8'h9C, 8'h0C, 8'hA8: return "R5";
      8'h10, 8'hAC:               return "R2";
      8'h04, 8'hA0, 8'h08, 8'hA4: return "R6";
      8'h14:                      return "R7";
      default: begin
        if (a[1:0] == 0 && ((a >= 8'h1C && a <= 8'h98) || (a >= 8'hB0 && a <= 8'hCC)))
          return "R9";
        return "R10";
      end
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare on every clock, away from the edge
  always @(posedge clk) begin
    #1ns;
    if (!done) begin
      check(rst ? "R1" : "R4", "irqOut", 32'(irqOut), 32'(mIrq));
      check(rst ? "R1" : "R3", "fiqOut", 32'(fiqOut), 32'(mFiq));
      check(rst ? "R1" : "R8", "wakeOut", 32'(wakeOut), 32'(mWake));
      check(rst ? "R1" : readTag(busAddr), "busRdData", busRdData, expRead(busAddr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    busAddr = a;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; srcIn = '0; halted = 1'b0;
    busAddr = 8'h14; busWrEn = 1'b0; busWrData = '0;
    idle(3);
    rst = 1'b0;
    // R1: reset state readback
    rd(8'h14); rd(8'h10); rd(8'h04);
    // R3 R4 R5: mixed steering in bank 0
    wr(8'h04, 32'h0000_FF0F);
    wr(8'h08, 32'h0000_F00F);
    srcIn[31:0] = 32'h0000_3311;
    idle(4);
    rd(8'h00); rd(8'h0C); rd(8'h10);
    // R2 R6: bank 1 with ignored upper data
    wr(8'hA0, 32'hFFFF_FF55);
    wr(8'hA4, 32'hFFFF_FF0F);
    srcIn[39:32] = 8'hA5;
    idle(4);
    rd(8'h9C); rd(8'hA8); rd(8'hAC); rd(8'hA0); rd(8'hA4);
    srcIn[31:0] = '0;
    idle(4);
    srcIn = '0;
    idle(4);
    // R8 R7: wake through idle mask while masked
    wr(8'h04, 32'h0); wr(8'hA0, 32'h0);
    srcIn[5] = 1'b1; srcIn[36] = 1'b1;
    halted = 1'b1;
    idle(4);
    wr(8'h14, 32'h0);
    idle(3); rd(8'h14);
    wr(8'h14, 32'h1);
    idle(3); rd(8'h14);
    wr(8'hA0, 32'h10);
    idle(3);
    halted = 1'b0;
    idle(2);
    // R9: priority words
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h98, 32'h1234_5678);
    wr(8'hB0, 32'h8000_0027);
    wr(8'hCC, 32'h7FFF_FFC1);
    rd(8'h1C); rd(8'h98); rd(8'hB0); rd(8'hCC);
    // R10: writes to read-only and undefined offsets
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h9C, 32'hFFFF_FFFF); wr(8'hA8, 32'hFFFF_FFFF);
    wr(8'hAC, 32'hFFFF_FFFF); wr(8'hD0, 32'hFFFF_FFFF); wr(8'h06, 32'hFFFF_FFFF);
    wr(8'h1D, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
    for (int a = 0; a < 256; a++) rd(8'(a));
    // Mixed activity across both banks
    wr(8'h04, 32'hA5A5_5A5A); wr(8'h08, 32'h0F0F_F0F0);
    wr(8'hA0, 32'h0000_00C3); wr(8'hA4, 32'h0000_0081);
    for (int k = 0; k < 300; k++) begin
      srcIn  = {8'($urandom), 32'($urandom)} & {8'($urandom), 32'($urandom)};
      halted = k[3];
      busAddr = 8'({$urandom} % 8'hD4);
      if (k % 37 == 5) wr(8'h14, 32'(k[6]));
      else @(negedge clk);
    end
    idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #400us;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule